// File: doc/BRIEF.md
# Packed Two-Entry Color Lookup Table

This block is a color lookup table for a display pipeline. It holds 256 color entries in 128 bus-addressable 32-bit words, two entries per word. A register bus writes and reads whole words inside a fixed address window. Reads return exactly what was written.

A pixel stream presents an 8-bit color index each cycle. One cycle later the block gives back a 24-bit color. Each stored entry is a 16-bit halfword holding three 5-bit channels and one spare flag bit. Every channel is widened to 8 bits by appending three zero bits.

Top module: `clut_packed`

## Requirements
- R1: The palette window covers byte addresses 0x200 through 0x3FC. Address bits [8:2] select word n, where n is the byte address minus 0x200, divided by 4. Accesses whose address lies outside the window neither modify the table nor return palette data; such reads return zero.
- R2: A bus read of word n, issued with `bus_rd` high, returns the full 32-bit value last written to that word. The value appears on `bus_rdata` in the cycle after the request.
- R3: Color index 2n selects bits [15:0] of word n, and index 2n+1 selects bits [31:16].
- R4: Within the selected halfword, red is bits [4:0], green is bits [9:5] and blue is bits [14:10].
- R5: Each 5-bit channel value c is output as the 8-bit value c*8, so the low three output bits are always zero.
- R6: Bit 15 of the halfword has no effect on any color output.
- R7: The color for an index sampled with `pix_valid` high appears on the outputs exactly one cycle later, with `pix_out_valid` high. `pix_out_valid` is low at other times, and the color outputs hold their value while no lookup is in progress.
- R8: If a bus write and a lookup address the same entry in the same cycle, the lookup returns the contents from before the write. The new value is seen by lookups made in later cycles.
- R9: After reset, `pix_out_valid` is low and the color outputs and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Color index |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_red | output | 8 | Expanded red |
| pix_green | output | 8 | Expanded green |
| pix_blue | output | 8 | Expanded blue |

## Verification
All 128 words are loaded with two patterns, and all 256 indices are then swept under each one.

The first pattern is derived from the word number, so a fault in word selection or in choosing the low or high halfword produces a wrong color. The second pattern puts a distinct marker in each channel and sets the flag bit in alternating halfwords; it separates swapped channel fields from leaking flag bits.

Further directed cases cover the following:
- a write and a lookup to the same entry in the same cycle;
- writes and reads outside the palette window;
- the lookup output holding steady while no request is made.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int CH_W      = 5;
    localparam int OUT_W     = 8;
    localparam int IDX_W     = 8;
    localparam int WORDS     = 128;
    localparam int WORD_AW   = $clog2(WORDS);
    localparam int HALF_W    = DATA_W / 2;
    localparam logic [ADDR_W-1:0] WIN_BASE = 12'h200;

    typedef struct packed {
        logic       flag;
        logic [CH_W-1:0] blue;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] red;
    } entry_t;

    typedef struct packed {
        logic [OUT_W-1:0] red;
        logic [OUT_W-1:0] green;
        logic [OUT_W-1:0] blue;
    } color_t;

    function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] c);
        return {c, {(OUT_W-CH_W){1'b0}}};
    endfunction

    function automatic color_t expand(input entry_t e);
        color_t o;
        o.red   = widen(e.red);
        o.green = widen(e.green);
        o.blue  = widen(e.blue);
        return o;
    endfunction
endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [WORD_AW-1:0] word
);
    localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(WORDS * 4);

    always_comb begin
        hit  = (addr >= WIN_BASE) && (addr < WIN_END);
        word = addr[WORD_AW+1:2];
    end
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [WORD_AW-1:0] raddr_a,
    output logic [DATA_W-1:0]  rdata_a,
    input  logic [WORD_AW-1:0] raddr_b,
    output logic [DATA_W-1:0]  rdata_b
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              half_sel,
    input  logic [DATA_W-1:0] word,
    output logic              out_valid,
    output color_t            color
);
    entry_t sel;

    always_comb sel = half_sel ? entry_t'(word[DATA_W-1:HALF_W])
                               : entry_t'(word[HALF_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            color     <= '0;
        end else begin
            out_valid <= req;
            if (req) color <= expand(sel);
        end
    end

    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (color.red[2:0] == 3'b0 && color.green[2:0] == 3'b0
                       && color.blue[2:0] == 3'b0));
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        req |=> out_valid);
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(color) && !out_valid);
endmodule

// File: rtl/clut_packed.sv
module clut_packed
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_index,
    output logic              pix_out_valid,
    output logic [OUT_W-1:0]  pix_red,
    output logic [OUT_W-1:0]  pix_green,
    output logic [OUT_W-1:0]  pix_blue
);
    logic               hit;
    logic [WORD_AW-1:0] bus_word;
    logic [DATA_W-1:0]  bus_word_data;
    logic [DATA_W-1:0]  pix_word_data;
    color_t             color;

    clut_decode u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .word (bus_word)
    );

    clut_store u_mem (
        .clk     (clk),
        .we      (bus_wr && hit),
        .waddr   (bus_word),
        .wdata   (bus_wdata),
        .raddr_a (bus_word),
        .rdata_a (bus_word_data),
        .raddr_b (pix_index[IDX_W-1:1]),
        .rdata_b (pix_word_data)
    );

    clut_lookup u_lk (
        .clk       (clk),
        .rst       (rst),
        .req       (pix_valid),
        .half_sel  (pix_index[0]),
        .word      (pix_word_data),
        .out_valid (pix_out_valid),
        .color     (color)
    );

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= hit ? bus_word_data : '0;
    end

    always_comb begin
        pix_red   = color.red;
        pix_green = color.green;
        pix_blue  = color.blue;
    end

    a_r1_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !hit) |=> bus_rdata == '0);
    a_r9_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !pix_out_valid && bus_rdata == '0);
endmodule

// File: tb/clut_packed_bench.sv
module clut_packed_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_rd = 0;
    logic [31:0] bus_rdata;
    logic        pix_valid = 0;
    logic [7:0]  pix_index = 0;
    logic        pix_out_valid;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [128];

    always #2 clk = ~clk;

    clut_packed u_clut_packed (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_color(input logic [7:0] idx);
        logic [15:0] h;
        h = idx[0] ? model[idx[7:1]][31:16] : model[idx[7:1]][15:0];
        return {h[4:0], 3'b0, h[9:5], 3'b0, h[14:10], 3'b0};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic look(input logic [7:0] idx, input string req);
        @(negedge clk);
        pix_index = idx; pix_valid = 1;
        @(negedge clk);
        pix_valid = 0;
        chk(req, {31'b0, pix_out_valid}, 32'd1);
        chk(req, {8'b0, pix_red, pix_green, pix_blue}, {8'b0, exp_color(idx)});
    endtask

    task automatic load(input int pat);
        for (int n = 0; n < 128; n++) begin
            logic [31:0] v;
            if (pat == 0) v = {n[7:0] + 8'h81, 8'hA5 ^ n[7:0], 8'h3C + n[7:0], n[7:0]} * 32'h9E37;
            else v = {n[0], 5'(n+3), 5'(n*7), 5'(n^5'h15), ~n[0], 5'(n+11), 5'(~n), 5'(n*3)};
            model[n] = v;
            wr(12'h200 + 12'(n*4), v);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual hang expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 valid", {31'b0, pix_out_valid}, 0);
        chk("R9 color", {8'b0, pix_red, pix_green, pix_blue}, 0);
        chk("R9 rdata", bus_rdata, 0);

        for (int p = 0; p < 2; p++) begin
            load(p);
            for (int n = 0; n < 128; n += 9) begin
                rd(12'h200 + 12'(n*4), d);
                chk("R2 readback", d, model[n]);
            end
            for (int i = 0; i < 256; i++)
                look(8'(i), "R3 R4 R5 R6 sweep");
        end

        wr(12'h1FC, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        rd(12'h1FC, d); chk("R1 below window read", d, 0);
        rd(12'h400, d); chk("R1 above window read", d, 0);
        rd(12'h3FC, d); chk("R1 last word intact", d, model[127]);
        rd(12'h200, d); chk("R1 first word intact", d, model[0]);

        model[5] = model[5] ^ 32'h8000_8000;
        wr(12'h214, model[5]);
        look(8'd10, "R6 flag flip low");
        look(8'd11, "R6 flag flip high");

        @(negedge clk);
        bus_addr = 12'h220; bus_wdata = 32'h7FFF_7FFF; bus_wr = 1;
        pix_index = 8'd16; pix_valid = 1;
        @(negedge clk);
        bus_wr = 0; pix_valid = 0;
        chk("R8 old value", {8'b0, pix_red, pix_green, pix_blue}, {8'b0, exp_color(8'd16)});
        model[8] = 32'h7FFF_7FFF;
        look(8'd16, "R8 new value later");

        @(negedge clk);
        chk("R7 valid low idle", {31'b0, pix_out_valid}, 0);
        chk("R7 hold", {8'b0, pix_red, pix_green, pix_blue}, {8'b0, exp_color(8'd16)});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule